// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block decides whether a single memory access may proceed under a table of sixteen protection regions. Each access is described by its byte address, its length in bytes (1 to 8), its kind (read, write or instruction fetch) and the privilege level of the requester. The current contents of the region address registers and the packed region configuration bytes are presented as flat buses. One clock after a request strobe, the block returns a deny flag for that request.

Each region either covers a span bounded below by the previous region's top address, or covers a naturally aligned block. That block is either exactly four bytes or a power-of-two size encoded in the trailing ones of the address register. The access is split into 4-byte sectors starting at the access address. The lowest-numbered region that any sector touches makes the decision. If that region covers only part of the access, the access is refused. Machine mode passes any region that is not locked. When no region matches, only machine mode is let through.

Top module: `pmp_checker`

## Requirements
- R1: After reset `rsp_valid` is 0 and `rsp_deny` is 1. A request with `req_valid` high gives `rsp_valid` high and its result on `rsp_deny` on the next clock edge. In a cycle with `req_valid` low, `rsp_valid` falls and `rsp_deny` keeps its value whatever the other inputs do.
- R2: Region i takes its configuration from bits [8i+7:8i] of `region_cfg`. Within that byte, bit 0 grants read, bit 1 grants write, bit 2 grants fetch, bits 4:3 select the match mode and bit 7 locks the region.
- R3: A region with mode 0 never matches. Its address register still serves as the lower bound of the next region.
- R4: In mode 1 (top of range), a byte address matches when it is at least four times the previous region's address register and below four times its own. For region 0 the lower bound is 0.
- R5: In mode 2, a region matches the four bytes starting at four times its address register.
- R6: In mode 3, the number of trailing ones k in the address register sets a region of 2^(k+3) bytes. The region is aligned to that size and contains four times the register value.
- R7: An access of 1 to 4 bytes is one sector at the access address. An access of 5 to 8 bytes adds a second sector at address+4. A region that matches some sectors but not all of them denies the access.
- R8: Among matching regions, the lowest index decides alone. Higher regions are not consulted.
- R9: For a fully matching region, machine mode (`req_priv` = 3) is allowed when the region is unlocked. A locked region applies its permission bits to machine mode as well.
- R10: Permission is selected by `req_kind`: 0 uses the read bit, 1 the write bit and 2 the fetch bit. Kind 3 grants nothing.
- R11: When no region matches, machine mode is allowed and every other privilege value (user = 0) is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Byte address of the access |
| req_len | input | 4 | Access length in bytes, 1 to 8 |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_priv | input | 2 | Privilege, 3 machine, 0 user |
| region_addr | input | 512 | Sixteen address registers, region i at bits [32i+31:32i], each a byte address shifted right by 2 |
| region_cfg | input | 128 | Sixteen configuration bytes, region i at bits [8i+7:8i] |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_deny | output | 1 | 1 when the access is refused |

## Verification
The assertions assume that `req_len` lies between 1 and 8 and that the inputs are driven to known values whenever `req_valid` is high. The bench only issues lengths of 4, 5 and 8 and drives every region field from a known table before each request. The properties on default behaviour depend on every region's mode field being zero. That case is reached only through the all-off table, while the populated table exercises overlapping, chained and locked regions.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_RANGE = 2'd1,
    MATCH_QUAD  = 2'd2,
    MATCH_POW2  = 2'd3
  } match_mode_e;

  localparam logic [1:0] PRIV_MACHINE = 2'd3;
  localparam int unsigned SECTOR_BYTES = 4;
endpackage

// File: rtl/pmp_region_match.sv
module pmp_region_match
  import pmp_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned MAX_LEN = 8,
  parameter int unsigned LEN_W   = 4
) (
  input  logic [AW-1:0]    addr,
  input  logic [LEN_W-1:0] len,
  input  match_mode_e      mode,
  input  logic [AW-1:0]    areg,
  input  logic [AW-1:0]    prev_areg,
  output logic             any_hit,
  output logic             all_hit
);
  localparam int unsigned W2    = AW + 2;
  localparam int unsigned NSECT = (MAX_LEN + SECTOR_BYTES - 1) / SECTOR_BYTES;

  logic [W2-1:0]    top_b;
  logic [W2-1:0]    low_b;
  logic [W2-1:0]    seed;
  logic [W2-1:0]    ones;
  logic [W2-1:0]    cmp_mask;
  logic [NSECT-1:0] act;
  logic [NSECT-1:0] hit;

  assign top_b    = {areg, 2'b00};
  assign low_b    = {prev_areg, 2'b00};
  assign seed     = {1'b0, areg, (mode != MATCH_QUAD)};
  assign ones     = seed & ~(seed + W2'(1));
  assign cmp_mask = (~ones) << 2;

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    logic [W2-1:0] sa;
    assign sa     = {2'b00, addr} + W2'(s * SECTOR_BYTES);
    assign act[s] = (32'(len) > 32'(s * SECTOR_BYTES));
    always_comb begin
      case (mode)
        MATCH_RANGE: hit[s] = (sa >= low_b) && (sa < top_b);
        MATCH_QUAD,
        MATCH_POW2:  hit[s] = ((sa ^ top_b) & cmp_mask) == '0;
        default:     hit[s] = 1'b0;
      endcase
    end
  end

  assign any_hit = |(hit & act);
  assign all_hit = &(hit | ~act);
endmodule

// File: rtl/pmp_decide.sv
module pmp_decide #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] any_hit,
  input  logic [N-1:0] all_hit,
  input  logic [N-1:0] perm_ok,
  input  logic [N-1:0] locked,
  input  logic         is_machine,
  output logic         allow
);
  always_comb begin
    allow = is_machine;
    for (int i = N - 1; i >= 0; i--) begin
      if (any_hit[i]) begin
        allow = all_hit[i] && ((is_machine && !locked[i]) || perm_ok[i]);
      end
    end
  end
endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned N       = 16,
  parameter int unsigned MAX_LEN = 8,
  parameter int unsigned LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [1:0]       req_kind,
  input  logic [1:0]       req_priv,
  input  logic [N*AW-1:0]  region_addr,
  input  logic [N*8-1:0]   region_cfg,
  output logic             rsp_valid,
  output logic             rsp_deny
);
  logic [N-1:0] any_hit;
  logic [N-1:0] all_hit;
  logic [N-1:0] perm_ok;
  logic [N-1:0] locked;
  logic         allow;
  logic         valid_d;
  logic         deny_d;

  for (genvar i = 0; i < N; i++) begin : g_region
    logic [7:0]    cfg_b;
    logic [AW-1:0] prev;
    assign cfg_b     = region_cfg[8*i +: 8];
    assign locked[i] = cfg_b[7];
    if (i == 0) begin : g_first
      assign prev = '0;
    end else begin : g_chain
      assign prev = region_addr[AW*(i-1) +: AW];
    end
    always_comb begin
      case (acc_kind_e'(req_kind))
        KIND_READ:  perm_ok[i] = cfg_b[0];
        KIND_WRITE: perm_ok[i] = cfg_b[1];
        KIND_FETCH: perm_ok[i] = cfg_b[2];
        default:    perm_ok[i] = 1'b0;
      endcase
    end
    pmp_region_match #(.AW(AW), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_match (
      .addr      (req_addr),
      .len       (req_len),
      .mode      (match_mode_e'(cfg_b[4:3])),
      .areg      (region_addr[AW*i +: AW]),
      .prev_areg (prev),
      .any_hit   (any_hit[i]),
      .all_hit   (all_hit[i])
    );
  end

  pmp_decide #(.N(N)) u_decide (
    .any_hit    (any_hit),
    .all_hit    (all_hit),
    .perm_ok    (perm_ok),
    .locked     (locked),
    .is_machine (req_priv == PRIV_MACHINE),
    .allow      (allow)
  );

  always_comb begin
    valid_d = req_valid;
    deny_d  = rsp_deny;
    if (req_valid) deny_d = ~allow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_deny  <= 1'b1;
    end else begin
      rsp_valid <= valid_d;
      rsp_deny  <= deny_d;
    end
  end
endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva #(
  parameter int unsigned AW    = 32,
  parameter int unsigned N     = 16,
  parameter int unsigned LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [LEN_W-1:0] req_len,
  input logic [1:0]       req_kind,
  input logic [1:0]       req_priv,
  input logic [N*8-1:0]   region_cfg,
  input logic             rsp_valid,
  input logic             rsp_deny
);
  logic all_off;
  always_comb begin
    all_off = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (region_cfg[8*i+3 +: 2] != 2'b00) all_off = 1'b0;
    end
  end

  // R1
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_deny)));

  // R11
  m_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && all_off && req_priv == 2'd3 && req_len != '0) |=> !rsp_deny);

  // R11
  low_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && all_off && req_priv != 2'd3) |=> rsp_deny);

  // R10
  rsvd_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv != 2'd3 && req_kind == 2'd3) |=> rsp_deny);
endmodule

bind pmp_checker pmp_checker_sva #(.AW(AW), .N(N), .LEN_W(LEN_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_len    (req_len),
  .req_kind   (req_kind),
  .req_priv   (req_priv),
  .region_cfg (region_cfg),
  .rsp_valid  (rsp_valid),
  .rsp_deny   (rsp_deny)
);

// File: tb/pmp_checker_tb.sv
`timescale 1ns/1ps
module pmp_checker_tb;
  localparam int AW = 32;
  localparam int N  = 16;

  typedef struct packed {
    logic        full;
    logic [31:0] addr;
    logic [3:0]  len;
    logic [1:0]  kind;
    logic [1:0]  priv;
    logic        deny;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC[NV] = '{
    '{1'b0, 32'h0000_0100, 4'd4, 2'd0, 2'd0, 1'b1, 8'd11}, // R11 user, nothing on
    '{1'b0, 32'h0000_0100, 4'd4, 2'd0, 2'd3, 1'b0, 8'd11}, // R11 machine, nothing on
    '{1'b1, 32'h0000_0100, 4'd4, 2'd0, 2'd0, 1'b0, 8'd4},  // R4 region 0 from zero
    '{1'b1, 32'h0000_0100, 4'd4, 2'd1, 2'd0, 1'b1, 8'd8},  // R8 region 0 beats region 7
    '{1'b1, 32'h0000_0100, 4'd4, 2'd1, 2'd3, 1'b0, 8'd9},  // R9 unlocked bypass
    '{1'b1, 32'h0000_0FFC, 4'd8, 2'd0, 2'd0, 1'b1, 8'd7},  // R7 straddle top
    '{1'b1, 32'h0000_0FFC, 4'd4, 2'd0, 2'd0, 1'b0, 8'd7},  // R7 one sector
    '{1'b1, 32'h0000_0FFC, 4'd5, 2'd0, 2'd0, 1'b1, 8'd7},  // R7 five bytes
    '{1'b1, 32'h0000_1000, 4'd4, 2'd1, 2'd0, 1'b0, 8'd8},  // R8 falls to region 7
    '{1'b1, 32'h0000_2000, 4'd4, 2'd1, 2'd0, 1'b0, 8'd5},  // R5 quad write
    '{1'b1, 32'h0000_2000, 4'd4, 2'd0, 2'd0, 1'b1, 8'd5},  // R5 quad no read
    '{1'b1, 32'h0000_2004, 4'd4, 2'd0, 2'd0, 1'b0, 8'd5},  // R5 quad extent
    '{1'b1, 32'h0000_30FC, 4'd4, 2'd1, 2'd0, 1'b0, 8'd6},  // R6 pow2 last word
    '{1'b1, 32'h0000_3100, 4'd4, 2'd1, 2'd0, 1'b1, 8'd4},  // R4 chained from pow2 reg
    '{1'b1, 32'h0000_3100, 4'd4, 2'd1, 2'd3, 1'b1, 8'd9},  // R9 locked applies to M
    '{1'b1, 32'h0000_3100, 4'd4, 2'd2, 2'd0, 1'b0, 8'd10}, // R10 fetch bit
    '{1'b1, 32'h0000_3080, 4'd4, 2'd0, 2'd0, 1'b0, 8'd8},  // R8 region 2 over 3
    '{1'b1, 32'h0000_30FC, 4'd8, 2'd0, 2'd0, 1'b1, 8'd7},  // R7 partial pow2
    '{1'b1, 32'h0000_5000, 4'd4, 2'd0, 2'd0, 1'b0, 8'd3},  // R3 bound from off region
    '{1'b1, 32'h0000_4FFC, 4'd4, 2'd1, 2'd0, 1'b0, 8'd3},  // R3 below chained bound
    '{1'b1, 32'h0000_5000, 4'd4, 2'd1, 2'd0, 1'b1, 8'd10}, // R10 write bit clear
    '{1'b1, 32'h0000_7000, 4'd4, 2'd0, 2'd3, 1'b1, 8'd9},  // R9 locked, no perms
    '{1'b1, 32'h0000_7004, 4'd4, 2'd0, 2'd3, 1'b0, 8'd9},  // R9 next word
    '{1'b1, 32'h0002_0000, 4'd4, 2'd0, 2'd0, 1'b0, 8'd2},  // R2 byte 13 read
    '{1'b1, 32'h0002_0000, 4'd4, 2'd1, 2'd0, 1'b1, 8'd2},  // R2 byte 13 no write
    '{1'b1, 32'h0002_0010, 4'd4, 2'd0, 2'd0, 1'b1, 8'd11}, // R11 user unmatched
    '{1'b1, 32'h0002_0010, 4'd4, 2'd0, 2'd3, 1'b0, 8'd11}, // R11 machine unmatched
    '{1'b1, 32'h0000_0100, 4'd4, 2'd3, 2'd0, 1'b1, 8'd10}  // R10 reserved kind
  };

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [3:0]    req_len;
  logic [1:0]    req_kind;
  logic [1:0]    req_priv;
  logic [N*AW-1:0] region_addr;
  logic [N*8-1:0]  region_cfg;
  logic          rsp_valid;
  logic          rsp_deny;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  pmp_checker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_kind(req_kind), .req_priv(req_priv),
    .region_addr(region_addr), .region_cfg(region_cfg),
    .rsp_valid(rsp_valid), .rsp_deny(rsp_deny)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_region(input int i, input logic [31:0] a, input logic [7:0] c);
    region_addr[AW*i +: AW] = a;
    region_cfg[8*i +: 8]    = c;
  endtask

  task automatic load_table(input logic full);
    region_addr = '0;
    region_cfg  = '0;
    if (full) begin
      set_region(0,  32'h0400, 8'h0D); // range to 0x1000, R X
      set_region(1,  32'h0800, 8'h12); // quad 0x2000, W
      set_region(2,  32'h0C1F, 8'h1B); // pow2 0x3000..0x30FF, R W
      set_region(3,  32'h1000, 8'h8C); // range 0x307C..0x3FFF, X, locked
      set_region(4,  32'h1400, 8'h00); // off, bound 0x5000
      set_region(5,  32'h1800, 8'h89); // range 0x5000..0x5FFF, R, locked
      set_region(6,  32'h1C00, 8'h90); // quad 0x7000, locked, none
      set_region(7,  32'h1FFF, 8'h1F); // pow2 0..0xFFFF, R W X
      set_region(13, 32'h8000, 8'h11); // quad 0x20000, R
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog actual=hang expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = 4'd4;
    req_kind = 2'd0; req_priv = 2'd0;
    load_table(1'b0);
    repeat (3) @(negedge clk);
    check("R1 reset rsp_valid", rsp_valid, 1'b0);
    check("R1 reset rsp_deny", rsp_deny, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      load_table(VEC[v].full);
      req_addr  = VEC[v].addr;
      req_len   = VEC[v].len;
      req_kind  = VEC[v].kind;
      req_priv  = VEC[v].priv;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check($sformatf("R%0d vec %0d valid", VEC[v].req, v), rsp_valid, 1'b1);
      check($sformatf("R%0d vec %0d deny", VEC[v].req, v), rsp_deny, VEC[v].deny);
    end

    // R1: last result was deny; idle cycles with an allowing stimulus keep it
    load_table(1'b1);
    req_addr = 32'h100; req_kind = 2'd0; req_priv = 2'd3;
    @(negedge clk);
    check("R1 idle rsp_valid low", rsp_valid, 1'b0);
    check("R1 idle deny held", rsp_deny, 1'b1);
    @(negedge clk);
    check("R1 idle deny still held", rsp_deny, 1'b1);

    // R1: back-to-back requests each update the result
    req_valid = 1'b1;
    @(negedge clk);
    check("R1 b2b first", rsp_deny, 1'b0);
    req_addr = 32'h7000;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 b2b second locked", rsp_deny, 1'b1);
    check("R1 b2b valid", rsp_valid, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule